// File: doc/BRIEF.md
# Protocol Discovery Responder

This block answers protocol-discovery requests that a mailbox has collected in its request buffer. When the mailbox pulses `start_i`, the responder first checks the request length. It then reads the request dword that carries the requested index and looks that index up in a table of protocols. The table is fixed by parameters and holds one vendor-ID and object-type pair per protocol.

The responder writes a three-dword response into the mailbox response buffer: two header dwords, then one payload dword. After that it reports completion with a one-cycle `done_o` pulse. `success_o` tells the mailbox whether to publish the response or discard the request. Index zero always describes the discovery protocol itself, and table entries are reached at index one and above. The total protocol count is `NUM_PROT + 1`, because it includes discovery.

Top module: `disc_responder`

## Requirements
- R1: While `rst_ni` is low and in the cycle after its release, `done_o`, `success_o`, `rsp_we_o` and `req_rd_en_o` are low.
- R2: A `start_i` seen in idle with `req_len_i` below 3 produces `done_o` high with `success_o` low in the next cycle, and no response write is made.
- R3: For a request of 3 or more dwords, the responder reads request dword 2 (`req_rd_en_o` high, `req_rd_addr_o` = 2) in the cycle after `start_i`. It takes the index from bits 7:0 of that dword and ignores bits 31:8.
- R4: The three response writes follow the read in three consecutive cycles, at response addresses 0, 1, 2 in that order.
- R5: Response dword 0 is 0x00000001 (vendor 0x0001 in bits 15:0, type 0x00 in bits 23:16, bits 31:24 zero). Response dword 1 is 0x00000003 (length 3 in bits 17:0).
- R6: For index 0 the payload reports vendor 0x0001 and type 0x00.
- R7: For index k with 1 <= k <= NUM_PROT, the payload reports table entry k-1. Entry j sits at `PROT_TABLE[24*j +: 24]`, with the vendor ID in bits 15:0 and the type in bits 23:16.
- R8: For an index of NUM_PROT+1 or above, the payload reports vendor 0xFFFF and type 0xFF.
- R9: Payload bits 31:24 hold the next index. It is 0 when index+1 equals NUM_PROT+1, and otherwise (index+1) mod 256. Vendor ID is in bits 15:0 and type in bits 23:16.
- R10: `done_o` is high for exactly one cycle, the cycle after the dword 2 write, and `success_o` is high with it there. `success_o` is never high without `done_o`.
- R11: `start_i` is ignored while a request is in progress: no extra read, write or `done_o` pulse results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Mailbox request to process the buffered object |
| req_len_i | input | LEN_W | Number of dwords held in the request buffer |
| req_rd_en_o | output | 1 | Request buffer read strobe |
| req_rd_addr_o | output | REQ_AW | Request buffer dword address |
| req_rd_data_i | input | 32 | Request buffer read data, valid in the same cycle as the address |
| rsp_we_o | output | 1 | Response buffer write enable |
| rsp_addr_o | output | 2 | Response buffer dword address |
| rsp_data_o | output | 32 | Response buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| success_o | output | 1 | Response valid; qualifies done_o |

## Verification
The assertions assume several things about the mailbox. `start_i` is only meaningful while the responder is idle. The request buffer returns the dword for `req_rd_addr_o` in the same cycle. `req_len_i` is stable in the cycle `start_i` is seen. The bench models the request buffer as a combinational word chosen by the read address. It drives `start_i` and `req_len_i` only at falling edges. It raises `start_i` during a busy period only in the test that checks it is ignored.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam logic [15:0] VID_STD   = 16'h0001;
  localparam logic [7:0]  TYPE_DISC = 8'h00;
  localparam int          RSP_DW    = 3;
  localparam int          REQ_IDX_DW = 2;

  typedef struct packed {
    logic [7:0]  obj_type;
    logic [15:0] vid;
  } proto_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WR_HDR0, ST_WR_HDR1, ST_WR_PAY, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/disc_lookup.sv
module disc_lookup
  import disc_pkg::*;
#(
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT*24-1:0] PROT_TABLE = '0
) (
  input  logic [7:0]  idx_i,
  output logic [31:0] payload_o
);
  localparam int TOTAL = NUM_PROT + 1;

  proto_ent_t ent [TOTAL];
  proto_ent_t sel;
  logic [7:0] nxt;

  assign ent[0] = '{obj_type: TYPE_DISC, vid: VID_STD};

  for (genvar g = 0; g < NUM_PROT; g++) begin : g_ent
    assign ent[g+1] = proto_ent_t'(PROT_TABLE[g*24 +: 24]);
  end

  always_comb begin
    sel = '{obj_type: 8'hFF, vid: 16'hFFFF};
    for (int k = 0; k < TOTAL; k++) begin
      if (idx_i == 8'(k)) sel = ent[k];
    end
  end

  always_comb begin
    nxt = idx_i + 8'd1;
    if (nxt == 8'(TOTAL)) nxt = 8'd0;
  end

  assign payload_o = {nxt, sel.obj_type, sel.vid};
endmodule

// File: rtl/disc_seq.sv
module disc_seq
  import disc_pkg::*;
#(
  parameter int LEN_W  = 19,
  parameter int REQ_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_rd_en_o,
  output logic [REQ_AW-1:0] req_rd_addr_o,
  input  logic [31:0]       req_rd_data_i,
  output logic [7:0]        idx_o,
  input  logic [31:0]       payload_i,
  output logic              rsp_we_o,
  output logic [1:0]        rsp_addr_o,
  output logic [31:0]       rsp_data_o,
  output logic              done_o,
  output logic              success_o
);
  seq_state_e state_q, state_d;
  logic [7:0] idx_q;
  logic       ok_q;
  logic       short_req;

  assign short_req = req_len_i < LEN_W'(RSP_DW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = short_req ? ST_FIN : ST_FETCH;
      ST_FETCH:   state_d = ST_WR_HDR0;
      ST_WR_HDR0: state_d = ST_WR_HDR1;
      ST_WR_HDR1: state_d = ST_WR_PAY;
      ST_WR_PAY:  state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) ok_q <= 1'b0;
      if (state_q == ST_FETCH)  idx_q <= req_rd_data_i[7:0];
      if (state_q == ST_WR_PAY) ok_q  <= 1'b1;
    end
  end

  assign req_rd_en_o   = state_q == ST_FETCH;
  assign req_rd_addr_o = REQ_AW'(REQ_IDX_DW);
  assign idx_o         = idx_q;

  always_comb begin
    rsp_we_o   = 1'b1;
    rsp_addr_o = 2'd0;
    rsp_data_o = '0;
    unique case (state_q)
      ST_WR_HDR0: rsp_data_o = {8'h00, TYPE_DISC, VID_STD};
      ST_WR_HDR1: begin
        rsp_addr_o = 2'd1;
        rsp_data_o = {14'd0, 18'(RSP_DW)};
      end
      ST_WR_PAY: begin
        rsp_addr_o = 2'd2;
        rsp_data_o = payload_i;
      end
      default: rsp_we_o = 1'b0;
    endcase
  end

  assign done_o    = state_q == ST_FIN;
  assign success_o = done_o && ok_q;

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_pay_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_we_o && rsp_addr_o == 2'd2) |=> (done_o && success_o));
  a_r4_hdr_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_we_o && rsp_addr_o == 2'd0) |=> (rsp_we_o && rsp_addr_o == 2'd1));
  a_r3_fetch_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rd_en_o |=> (rsp_we_o && rsp_addr_o == 2'd0));
  a_r2_short_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && short_req) |=> (done_o && !success_o));
  a_r11_busy_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !req_rd_en_o || $past(state_q == ST_IDLE));
endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int NUM_PROT = 2,
  parameter logic [NUM_PROT*24-1:0] PROT_TABLE = {8'h7E, 16'hABCD, 8'h05, 16'h1234},
  parameter int LEN_W  = 19,
  parameter int REQ_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_rd_en_o,
  output logic [REQ_AW-1:0] req_rd_addr_o,
  input  logic [31:0]       req_rd_data_i,
  output logic              rsp_we_o,
  output logic [1:0]        rsp_addr_o,
  output logic [31:0]       rsp_data_o,
  output logic              done_o,
  output logic              success_o
);
  logic [7:0]  idx;
  logic [31:0] payload;

  disc_seq #(.LEN_W(LEN_W), .REQ_AW(REQ_AW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .req_len_i     (req_len_i),
    .req_rd_en_o   (req_rd_en_o),
    .req_rd_addr_o (req_rd_addr_o),
    .req_rd_data_i (req_rd_data_i),
    .idx_o         (idx),
    .payload_i     (payload),
    .rsp_we_o      (rsp_we_o),
    .rsp_addr_o    (rsp_addr_o),
    .rsp_data_o    (rsp_data_o),
    .done_o        (done_o),
    .success_o     (success_o)
  );

  disc_lookup #(.NUM_PROT(NUM_PROT), .PROT_TABLE(PROT_TABLE)) u_lookup (
    .idx_i     (idx),
    .payload_o (payload)
  );

  a_r10_success_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    success_o |-> done_o);
endmodule

// File: tb/disc_responder_bench.sv
module disc_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [31:0] V_WORD [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                                          32'h0000_0003, 32'h0000_00FF, 32'hABCD_0101};
  localparam logic [18:0] V_LEN  [NV] = '{19'd3, 19'd3, 19'd4, 19'd3, 19'd3, 19'd5};
  localparam logic [31:0] V_PAY  [NV] = '{32'h0100_0001, 32'h0205_1234, 32'h007E_ABCD,
                                          32'h04FF_FFFF, 32'h00FF_FFFF, 32'h0205_1234};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [18:0] req_len = '0;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] word2 = '0;
  logic [31:0] rd_data;
  logic        we;
  logic [1:0]  waddr;
  logic [31:0] wdata;
  logic        done;
  logic        ok;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_wr = 0;
  int n_rd = 0;
  int n_rd_bad = 0;
  logic [1:0]  wa [8];
  logic [31:0] wd [8];

  assign rd_data = (rd_addr == 8'd2) ? word2 : 32'h0;

  disc_responder u_disc_responder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .req_len_i(req_len),
    .req_rd_en_o(rd_en), .req_rd_addr_o(rd_addr), .req_rd_data_i(rd_data),
    .rsp_we_o(we), .rsp_addr_o(waddr), .rsp_data_o(wdata),
    .done_o(done), .success_o(ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (we) begin
      if (n_wr < 8) begin
        wa[n_wr] = waddr;
        wd[n_wr] = wdata;
      end
      n_wr = n_wr + 1;
    end
    if (rd_en) begin
      n_rd = n_rd + 1;
      if (rd_addr != 8'd2) n_rd_bad = n_rd_bad + 1;
    end
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Runs one request; busy_poke raises start again while busy (R11).
  task automatic run(input logic [31:0] w2, input logic [18:0] len, input bit exp_ok,
                     input logic [31:0] exp_pay, input bit busy_poke);
    int n;
    @(negedge clk);
    n_wr = 0; n_rd = 0; n_rd_bad = 0;
    word2 = w2; req_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (busy_poke) begin
      start = 1'b1; req_len = 19'd1;
    end
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
      if (n == 3) begin start = 1'b0; req_len = len; end
    end
    start = 1'b0;
    chk(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
    chk(n == (exp_ok ? 5 : 1), exp_ok ? "R4 done cycle" : "R2 done cycle", 32'(n), exp_ok ? 32'd5 : 32'd1);
    chk(ok == exp_ok, exp_ok ? "R10 success" : "R2 failure", 32'(ok), 32'(exp_ok));
    if (exp_ok) begin
      chk(n_wr == 3, "R4 write count", 32'(n_wr), 32'd3);
      chk(n_rd == 1 && n_rd_bad == 0, "R3 read of dword 2", 32'(n_rd), 32'd1);
      chk(wa[0] == 2'd0 && wa[1] == 2'd1 && wa[2] == 2'd2, "R4 address order",
          {26'd0, wa[0], wa[1], wa[2]}, 32'h6);
      chk(wd[0] == 32'h0000_0001, "R5 header dword 0", wd[0], 32'h0000_0001);
      chk(wd[1] == 32'h0000_0003, "R5 header dword 1", wd[1], 32'h0000_0003);
      chk(wd[2] == exp_pay, "R6 R7 R8 R9 payload", wd[2], exp_pay);
    end else begin
      chk(n_wr == 0 && n_rd == 0, "R2 no access", 32'(n_wr + n_rd), 32'd0);
    end
    @(negedge clk);
    chk(done == 1'b0 && ok == 1'b0, "R10 single pulse", {30'd0, done, ok}, 32'd0);
    if (busy_poke) begin
      repeat (3) @(negedge clk);
      chk(n_wr == 3 && !done, "R11 busy start ignored", 32'(n_wr), 32'd3);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!done && !ok && !we && !rd_en, "R1 in reset", {28'd0, done, ok, we, rd_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !ok && !we && !rd_en, "R1 after release", {28'd0, done, ok, we, rd_en}, 32'd0);

    for (int i = 0; i < NV; i++) run(V_WORD[i], V_LEN[i], 1'b1, V_PAY[i], 1'b0);

    // R2 short requests
    run(32'h0, 19'd2, 1'b0, 32'h0, 1'b0);
    run(32'h0, 19'd0, 1'b0, 32'h0, 1'b0);
    // R11 start while busy
    run(32'h0000_0002, 19'd3, 1'b1, 32'h007E_ABCD, 1'b1);

    // R1 reset mid-request
    @(negedge clk);
    word2 = 32'h1; req_len = 19'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!done && !ok && !we && !rd_en, "R1 mid-request reset", {28'd0, done, ok, we, rd_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !we, "R1 stays idle", {30'd0, done, we}, 32'd0);
    // after reset a normal request still works
    run(32'h0000_0001, 19'd3, 1'b1, 32'h0205_1234, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule